// File: doc/BRIEF.md
# Eight-Bit Register-File ALU with In-File Flag

This block pairs a sixteen-entry, 8-bit register file with the arithmetic and logic unit of a small virtual processor. A four-bit operation code and two register indices, X and Y, come in with a valid strobe. Both registers are read combinationally, the result is written back to register X, and, for the operations that define one, a one-bit flag is written into the last register (index 15). That register is also an ordinary general register. An add-immediate path adds an 8-bit constant to X without touching the flag register.

Every write happens on one rising clock edge while the strobe is high. Codes that name no operation raise an illegal-operation output and write nothing. The two read values are brought out as ports, so the processor around the block can use them and the contents of any register can be observed.

Top module: `flag_alu_core`

## Requirements
- R1: While rst_ni is low, all sixteen registers are cleared to 0, and both read ports return 0 for any index.
- R2: Code 0x0 copies register Y into register X. Register 15 is not otherwise written.
- R3: Codes 0x1, 0x2 and 0x3 write X|Y, X&Y and X^Y into X. Register 15 is not otherwise written.
- R4: Code 0x4 writes the low 8 bits of X+Y into X. Register 15 becomes 1 when the true sum exceeds 255 and 0 otherwise.
- R5: Code 0x5 writes the 8-bit X−Y into X. Register 15 becomes 1 only when X is strictly greater than Y.
- R6: Code 0x7 writes the 8-bit Y−X into X. Register 15 becomes 1 only when Y is strictly greater than X.
- R7: Code 0x6 writes X shifted right by one into X and puts the old bit 0 of X into register 15. The value of Y has no effect.
- R8: Code 0xE writes X shifted left by one, kept to 8 bits, into X and puts the old bit 7 of X into register 15.
- R9: With imm_mode_i high, X receives X+imm_i modulo 256. The operation code is ignored and register 15 keeps its value unless X is 15.
- R10: With imm_mode_i low and valid_i high, codes 0x8 to 0xD and 0xF drive illegal_o high in the same cycle and write no register. illegal_o is low otherwise.
- R11: When X is 15 and the operation defines a flag, register 15 ends up holding the flag value, not the arithmetic result.
- R12: With valid_i low, no register changes at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all writes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| imm_mode_i | input | 1 | Selects the add-immediate path |
| op_i | input | 4 | Operation code |
| x_idx_i | input | 4 | Index of X (source and destination) |
| y_idx_i | input | 4 | Index of Y (second source) |
| imm_i | input | 8 | Constant for the add-immediate path |
| x_val_o | output | 8 | Current content of register X |
| y_val_o | output | 8 | Current content of register Y |
| illegal_o | output | 1 | Undefined operation code under a valid strobe |

## Verification
Every defined operation is run over a grid of X and Y operand pairs. The grid covers both operands zero, equal operands, sums just under and over 255, and values with bit 0 or bit 7 set. These patterns separate carry from no carry, strict greater-than from equality in both subtractions, and which end bit each shift moves into the flag. A known value is placed in register 15 before every operation, so a flag written by an operation that should leave it alone shows up as a changed value. Separate patterns drive each undefined code, a strobe held low, the immediate path with a non-add code present, X aliased to register 15, and a reset in the middle of operation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_COPY = 4'h0,
    OP_OR   = 4'h1,
    OP_AND  = 4'h2,
    OP_XOR  = 4'h3,
    OP_ADD  = 4'h4,
    OP_SUB  = 4'h5,
    OP_SHR  = 4'h6,
    OP_RSUB = 4'h7,
    OP_SHL  = 4'hE
  } alu_op_e;
endpackage

// File: rtl/flag_alu_exec.sv
module flag_alu_exec
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              valid_i,
  input  logic              imm_mode_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic              flag_o,
  output logic              flag_we_o,
  output logic              illegal_o
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] sum_w;
  logic [DATA_W-1:0] res_c;
  logic              flag_c, flag_def, res_def, bad_op;

  assign sum_w = {1'b0, x_i} + {1'b0, y_i};

  always_comb begin
    res_c    = '0;
    flag_c   = 1'b0;
    flag_def = 1'b0;
    res_def  = 1'b0;
    bad_op   = 1'b0;
    if (imm_mode_i) begin
      res_c   = x_i + imm_i;
      res_def = 1'b1;
    end else begin
      unique case (op_i)
        OP_COPY: begin res_c = y_i;       res_def = 1'b1; end
        OP_OR:   begin res_c = x_i | y_i; res_def = 1'b1; end
        OP_AND:  begin res_c = x_i & y_i; res_def = 1'b1; end
        OP_XOR:  begin res_c = x_i ^ y_i; res_def = 1'b1; end
        OP_ADD: begin
          res_c = sum_w[DATA_W-1:0]; flag_c = sum_w[DATA_W];
          res_def = 1'b1; flag_def = 1'b1;
        end
        OP_SUB: begin
          res_c = x_i - y_i; flag_c = (x_i > y_i);
          res_def = 1'b1; flag_def = 1'b1;
        end
        OP_RSUB: begin
          res_c = y_i - x_i; flag_c = (y_i > x_i);
          res_def = 1'b1; flag_def = 1'b1;
        end
        OP_SHR: begin
          res_c = x_i >> 1; flag_c = x_i[0];
          res_def = 1'b1; flag_def = 1'b1;
        end
        OP_SHL: begin
          res_c = x_i << 1; flag_c = x_i[DATA_W-1];
          res_def = 1'b1; flag_def = 1'b1;
        end
        default: bad_op = 1'b1;
      endcase
    end
  end

  assign res_o     = res_c;
  assign flag_o    = flag_c;
  assign res_we_o  = valid_i & res_def;
  assign flag_we_o = valid_i & flag_def;
  assign illegal_o = valid_i & bad_op;
endmodule

// File: rtl/flag_alu_regfile.sv
module flag_alu_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int FLAG_IDX = NUM_REGS - 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [IDX_W-1:0]                 x_idx_i,
  input  logic [IDX_W-1:0]                 y_idx_i,
  input  logic                             res_we_i,
  input  logic [DATA_W-1:0]                res_i,
  input  logic                             flag_we_i,
  input  logic                             flag_i,
  output logic [DATA_W-1:0]                x_val_o,
  output logic [DATA_W-1:0]                y_val_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] flag_word;

  assign flag_word = {{(DATA_W-1){1'b0}}, flag_i};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (flag_we_i && (g == FLAG_IDX)) begin
        // flag beats result when X aliases the flag register
        regs_q[g] <= flag_word;
      end else if (res_we_i && (x_idx_i == IDX_W'(g))) begin
        regs_q[g] <= res_i;
      end
    end
    assign regs_o[g] = regs_q[g];
  end

  assign x_val_o = regs_q[x_idx_i];
  assign y_val_o = regs_q[y_idx_i];
endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              imm_mode_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  x_idx_i,
  input  logic [IDX_W-1:0]  y_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] x_val_o,
  output logic [DATA_W-1:0] y_val_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0]               res_w;
  logic                            res_we_w, flag_w, flag_we_w;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_w;

  flag_alu_exec #(.DATA_W(DATA_W)) exec_i (
    .valid_i   (valid_i),
    .imm_mode_i(imm_mode_i),
    .op_i      (op_i),
    .x_i       (x_val_o),
    .y_i       (y_val_o),
    .imm_i     (imm_i),
    .res_o     (res_w),
    .res_we_o  (res_we_w),
    .flag_o    (flag_w),
    .flag_we_o (flag_we_w),
    .illegal_o (illegal_o)
  );

  flag_alu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rf_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x_idx_i  (x_idx_i),
    .y_idx_i  (y_idx_i),
    .res_we_i (res_we_w),
    .res_i    (res_w),
    .flag_we_i(flag_we_w),
    .flag_i   (flag_w),
    .x_val_o  (x_val_o),
    .y_val_o  (y_val_o),
    .regs_o   (regs_w)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int FLAG_IDX = NUM_REGS - 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            valid_i,
  input logic                            imm_mode_i,
  input logic [OP_W-1:0]                 op_i,
  input logic [IDX_W-1:0]                x_idx_i,
  input logic [DATA_W-1:0]               x_val_o,
  input logic [DATA_W-1:0]               y_val_o,
  input logic                            illegal_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_i
);
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(regs_i));

  // R10
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(regs_i));

  // R10
  illegal_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_i && !imm_mode_i));

  // R4
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !imm_mode_i && op_i == OP_ADD) |=>
      regs_i[FLAG_IDX] == DATA_W'(({1'b0, $past(x_val_o)} + {1'b0, $past(y_val_o)}) >> DATA_W));

  // R7
  shr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !imm_mode_i && op_i == OP_SHR && x_idx_i != IDX_W'(FLAG_IDX)) |=>
      (regs_i[$past(x_idx_i)] == ($past(x_val_o) >> 1)) &&
      (regs_i[FLAG_IDX] == DATA_W'($past(x_val_o[0]))));

  // R9
  imm_flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_mode_i && x_idx_i != IDX_W'(FLAG_IDX)) |=>
      $stable(regs_i[FLAG_IDX]));
endmodule

bind flag_alu_core flag_alu_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .imm_mode_i(imm_mode_i),
  .op_i      (op_i),
  .x_idx_i   (x_idx_i),
  .x_val_o   (x_val_o),
  .y_val_o   (y_val_o),
  .illegal_o (illegal_o),
  .regs_i    (regs_w)
);

// File: tb/flag_alu_core_tb_top.sv
module flag_alu_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       valid_i = 1'b0;
  logic       imm_mode_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [3:0] x_idx_i = '0;
  logic [3:0] y_idx_i = '0;
  logic [7:0] imm_i = '0;
  logic [7:0] x_val_o, y_val_o;
  logic       illegal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [7:0] SENT = 8'h5A;

  always #2 clk_i = ~clk_i;

  flag_alu_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .imm_mode_i(imm_mode_i),
    .op_i(op_i), .x_idx_i(x_idx_i), .y_idx_i(y_idx_i), .imm_i(imm_i),
    .x_val_o(x_val_o), .y_val_o(y_val_o), .illegal_o(illegal_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic peek(input logic [3:0] r, output logic [7:0] v);
    x_idx_i = r;
    #1 v = x_val_o;
  endtask

  task automatic set_reg(input logic [3:0] r, input logic [7:0] v);
    logic [7:0] cur;
    @(negedge clk_i);
    peek(r, cur);
    imm_mode_i = 1'b1;
    imm_i = v - cur;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    imm_mode_i = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [3:0] x, input logic [3:0] y);
    @(negedge clk_i);
    op_i = op; x_idx_i = x; y_idx_i = y; imm_mode_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // [9] flag written, [8] flag value, [7:0] result
  function automatic logic [9:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    int s;
    case (op)
      4'h0: return {2'b00, b};
      4'h1: return {2'b00, a | b};
      4'h2: return {2'b00, a & b};
      4'h3: return {2'b00, a ^ b};
      4'h4: begin s = int'(a) + int'(b); return {1'b1, s > 255, 8'(s)}; end
      4'h5: return {1'b1, a > b, 8'(a - b)};
      4'h7: return {1'b1, b > a, 8'(b - a)};
      4'h6: return {1'b1, a[0], 8'(a >> 1)};
      4'hE: return {1'b1, a[7], 8'(a << 1)};
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'h0: return "R2";
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4: return "R4";
      4'h5: return "R5";
      4'h7: return "R6";
      4'h6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic one_case(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [9:0] e;
    e = model(op, a, b);
    set_reg(4'd3, a);
    set_reg(4'd5, b);
    set_reg(4'd15, SENT);
    run_op(op, 4'd3, 4'd5);
    x_idx_i = 4'd3; y_idx_i = 4'd15;
    #1;
    check(tag(op), x_val_o, e[7:0]);
    check(tag(op), y_val_o, e[9] ? {7'b0, e[8]} : SENT);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [3:0] ops [9];
    ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE};
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int r = 0; r < 16; r++) begin
      x_idx_i = 4'(r); y_idx_i = 4'(r);
      #1;
      check("R1", x_val_o, 0);
      check("R1", y_val_o, 0);
    end
    rst_ni = 1'b1;

    // R2..R8 grid sweep
    foreach (ops[k]) begin
      for (int a = 0; a < 256; a += 9)
        for (int b = 0; b < 256; b += 11)
          one_case(ops[k], 8'(a), 8'(b));
      one_case(ops[k], 8'd200, 8'd200);
      one_case(ops[k], 8'd255, 8'd1);
      one_case(ops[k], 8'd128, 8'd127);
      one_case(ops[k], 8'd255, 8'd255);
    end

    // R7: Y has no effect on shift right
    one_case(4'h6, 8'h81, 8'h00);
    one_case(4'h6, 8'h81, 8'hFF);

    // R10: undefined codes raise illegal_o and write nothing
    for (int c = 8; c < 16; c++) begin
      if (c == 14) continue;
      set_reg(4'd3, 8'h33);
      set_reg(4'd5, 8'h44);
      set_reg(4'd15, SENT);
      @(negedge clk_i);
      op_i = 4'(c); x_idx_i = 4'd3; y_idx_i = 4'd5; valid_i = 1'b1;
      #1 check("R10", illegal_o, 1);
      @(negedge clk_i);
      valid_i = 1'b0;
      #1 check("R10", illegal_o, 0);
      peek(4'd3, v); check("R10", v, 8'h33);
      peek(4'd15, v); check("R10", v, SENT);
    end
    // R10: legal code does not raise illegal_o
    @(negedge clk_i);
    op_i = 4'h4; valid_i = 1'b1;
    #1 check("R10", illegal_o, 0);
    valid_i = 1'b0;

    // R12: strobe low writes nothing
    set_reg(4'd3, 8'hF0);
    set_reg(4'd5, 8'h20);
    set_reg(4'd15, SENT);
    @(negedge clk_i);
    op_i = 4'h4; x_idx_i = 4'd3; y_idx_i = 4'd5; valid_i = 1'b0;
    @(negedge clk_i);
    peek(4'd3, v); check("R12", v, 8'hF0);
    peek(4'd15, v); check("R12", v, SENT);

    // R9: immediate path wraps, ignores op, keeps flag register
    set_reg(4'd3, 8'd250);
    set_reg(4'd15, SENT);
    @(negedge clk_i);
    op_i = 4'h4; x_idx_i = 4'd3; y_idx_i = 4'd15; imm_mode_i = 1'b1; imm_i = 8'd10; valid_i = 1'b1;
    #1 check("R9", illegal_o, 0);
    @(negedge clk_i);
    valid_i = 1'b0; imm_mode_i = 1'b0;
    #1;
    check("R9", x_val_o, 8'd4);
    check("R9", y_val_o, SENT);

    // R11: X aliases flag register; flag wins
    set_reg(4'd15, 8'd200);
    set_reg(4'd5, 8'd100);
    run_op(4'h4, 4'd15, 4'd5);
    peek(4'd15, v); check("R11", v, 1);
    set_reg(4'd15, 8'd10);
    set_reg(4'd5, 8'd3);
    run_op(4'h5, 4'd15, 4'd5);
    peek(4'd15, v); check("R11", v, 1);
    // non-flag op on register 15 stores the result
    set_reg(4'd15, 8'h0F);
    set_reg(4'd5, 8'hF0);
    run_op(4'h1, 4'd15, 4'd5);
    peek(4'd15, v); check("R3", v, 8'hFF);

    // R1: reset in mid-operation clears
    set_reg(4'd7, 8'h77);
    @(negedge clk_i);
    rst_ni = 1'b0;
    peek(4'd7, v); check("R1", v, 0);
    peek(4'd15, v); check("R1", v, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule